// File: doc/BRIEF.md
# Image Conversion DMA Register and Sequencing Block

This block is the software-facing control point of an image-conversion DMA. It sits on an APB3 bus as a zero-wait-state slave. Software loads a source base, a destination base, an image width and an image height, then issues a launch command. The block drives these settings, together with the total pixel count of the frame (width times height), to the read and write engines.

On launch it sends the engines a one-cycle start pulse and holds a busy flag until the write engine reports that it has accepted the final output beat. At that point busy drops and a sticky done flag is set. The interrupt line is the level of done gated by an enable bit. Software clears done by writing a one to it, and a new launch also clears it.

The source and destination bases are confined to fixed address windows. A base outside its window is never loaded. While a frame is in flight, the frame settings are frozen.

Top module: `imgdma_cfg`

## Requirements
- R1: After reset the source base reads 0x60000000, the destination base reads 0x63000000, and width, height, control and status all read 0. The start pulse, busy and the interrupt are low.
- R2: Every APB transfer completes with no wait state and no error: pready is always 1 and pslverr is always 0.
- R3: The register map decodes these word offsets: 0x00 source base, 0x04 destination base, 0x08 width (low DIM_W bits, upper bits read 0), 0x0C height (same layout), 0x10 control (bit1 interrupt enable, bit0 launch, which always reads 0), 0x14 status (bit0 busy, bit1 done). Any other offset, including a misaligned one, reads 0, and a write to it changes nothing.
- R4: A write to the source base with a value outside 0x60000000..0x61FFFFFF is ignored. A write to the destination base with a value outside 0x63000000..0x65FFFFFF is ignored.
- R5: When idle, a control write with bit0 = 1 raises start_pulse for exactly one cycle, in the cycle after the APB access edge. Busy is high from the following cycle.
- R6: A control write with bit0 = 1 while busy produces no start pulse. The interrupt enable bit in that same write is still stored.
- R7: Writes to source, destination, width or height are ignored from the launch until busy falls.
- R8: pixel_count always equals width times height, with no truncation.
- R9: wr_last_done while busy clears busy and sets done on the next cycle. wr_last_done while idle has no effect.
- R10: Writing status with bit1 = 1 clears done, and bit1 = 0 leaves it. If wr_last_done arrives in the same cycle as the clearing write, done ends set. A launch clears done.
- R11: irq equals done AND the interrupt enable bit at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | PADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, 0 when not selected |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| src_addr | output | 32 | Source base to the read engine |
| dst_addr | output | 32 | Destination base to the write engine |
| img_width | output | DIM_W | Image width in pixels |
| img_height | output | DIM_W | Image height in lines |
| pixel_count | output | 2*DIM_W | Width times height |
| start_pulse | output | 1 | One-cycle launch to the engines |
| busy | output | 1 | Frame in flight |
| wr_last_done | input | 1 | Write engine accepted the final beat |
| irq | output | 1 | Level interrupt |

## Verification
The bench checks that an out-of-window base leaves the old value readable. A design that range-checked only one edge of a window would load 0x5FFFFFFC or 0x66000000.

It issues launch writes and dimension writes during a frame. A design without the lock would emit a second pulse or change the geometry under the engines.

It lands wr_last_done in the same cycle as a done-clearing write. A design that gave priority to the clear would lose the completion.

It checks that the interrupt follows the enable bit both ways after completion, and that an idle wr_last_done leaves status at zero.

// File: rtl/imgdma_pkg.sv
package imgdma_pkg;

    localparam int unsigned REG_W = 32;
    localparam int unsigned OFS_W = 8;

    localparam logic [OFS_W-1:0] OFS_SRC = 8'h00;
    localparam logic [OFS_W-1:0] OFS_DST = 8'h04;
    localparam logic [OFS_W-1:0] OFS_WID = 8'h08;
    localparam logic [OFS_W-1:0] OFS_HGT = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_CTL = 8'h10;
    localparam logic [OFS_W-1:0] OFS_STS = 8'h14;

    localparam int unsigned CTL_GO   = 0;
    localparam int unsigned CTL_IEN  = 1;
    localparam int unsigned STS_BUSY = 0;
    localparam int unsigned STS_DONE = 1;

    typedef enum logic [2:0] {
        RSEL_SRC,
        RSEL_DST,
        RSEL_WID,
        RSEL_HGT,
        RSEL_CTL,
        RSEL_STS,
        RSEL_NONE
    } rsel_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LAUNCH,
        PH_RUN
    } phase_e;

    typedef struct packed {
        logic             wr;
        rsel_e            sel;
        logic [REG_W-1:0] wdata;
    } apb_req_t;

    function automatic rsel_e decode_offset(input logic [OFS_W-1:0] ofs);
        rsel_e r;
        case (ofs)
            OFS_SRC: r = RSEL_SRC;
            OFS_DST: r = RSEL_DST;
            OFS_WID: r = RSEL_WID;
            OFS_HGT: r = RSEL_HGT;
            OFS_CTL: r = RSEL_CTL;
            OFS_STS: r = RSEL_STS;
            default: r = RSEL_NONE;
        endcase
        return r;
    endfunction

    function automatic logic in_window(input logic [REG_W-1:0] v,
                                       input logic [REG_W-1:0] lo,
                                       input logic [REG_W-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/imgdma_apb_dec.sv
module imgdma_apb_dec
    import imgdma_pkg::*;
#(
    parameter int unsigned PADDR_W = 12
) (
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [PADDR_W-1:0] paddr,
    input  logic [REG_W-1:0]   pwdata,
    output apb_req_t           req
);

    logic [OFS_W-1:0] low_ofs;
    logic             upper_zero;

    generate
        if (PADDR_W > OFS_W) begin : g_wide
            assign low_ofs    = paddr[OFS_W-1:0];
            assign upper_zero = (paddr[PADDR_W-1:OFS_W] == '0);
        end else begin : g_narrow
            assign low_ofs    = OFS_W'(paddr);
            assign upper_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        req.wr    = psel && penable && pwrite;
        req.sel   = upper_zero ? decode_offset(low_ofs) : RSEL_NONE;
        req.wdata = pwdata;
    end

endmodule

// File: rtl/imgdma_cfg_regs.sv
module imgdma_cfg_regs
    import imgdma_pkg::*;
#(
    parameter int unsigned     DIM_W  = 16,
    parameter logic [REG_W-1:0] SRC_LO = 32'h6000_0000,
    parameter logic [REG_W-1:0] SRC_HI = 32'h61FF_FFFF,
    parameter logic [REG_W-1:0] DST_LO = 32'h6300_0000,
    parameter logic [REG_W-1:0] DST_HI = 32'h65FF_FFFF,
    localparam int unsigned    PIX_W  = 2 * DIM_W
) (
    input  logic             clk,
    input  logic             rst,
    input  apb_req_t         req,
    input  logic             lock,
    output logic [REG_W-1:0] src_addr,
    output logic [REG_W-1:0] dst_addr,
    output logic [DIM_W-1:0] img_width,
    output logic [DIM_W-1:0] img_height,
    output logic [PIX_W-1:0] pixel_count
);

    localparam int unsigned N_DIM = 2;

    logic             open_wr;
    logic [REG_W-1:0] src_q;
    logic [REG_W-1:0] dst_q;
    logic [DIM_W-1:0] dim_q [N_DIM];

    assign open_wr = req.wr && !lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= SRC_LO;
            dst_q <= DST_LO;
        end else begin
            if (open_wr && req.sel == RSEL_SRC && in_window(req.wdata, SRC_LO, SRC_HI))
                src_q <= req.wdata;
            if (open_wr && req.sel == RSEL_DST && in_window(req.wdata, DST_LO, DST_HI))
                dst_q <= req.wdata;
        end
    end

    generate
        for (genvar g = 0; g < N_DIM; g++) begin : g_dim
            localparam rsel_e MY_SEL = (g == 0) ? RSEL_WID : RSEL_HGT;
            always_ff @(posedge clk) begin
                if (rst)
                    dim_q[g] <= '0;
                else if (open_wr && req.sel == MY_SEL)
                    dim_q[g] <= req.wdata[DIM_W-1:0];
            end
        end
    endgenerate

    assign src_addr    = src_q;
    assign dst_addr    = dst_q;
    assign img_width   = dim_q[0];
    assign img_height  = dim_q[1];
    assign pixel_count = PIX_W'(dim_q[0]) * PIX_W'(dim_q[1]);

endmodule

// File: rtl/imgdma_seq.sv
module imgdma_seq
    import imgdma_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  apb_req_t req,
    input  logic     wr_last_done,
    output logic     lock,
    output logic     start_pulse,
    output logic     busy,
    output logic     done,
    output logic     ien,
    output logic     irq
);

    phase_e phase_q;
    logic   done_q;
    logic   ien_q;
    logic   ctl_wr;
    logic   sts_wr;
    logic   go_req;

    assign ctl_wr = req.wr && (req.sel == RSEL_CTL);
    assign sts_wr = req.wr && (req.sel == RSEL_STS);
    assign go_req = ctl_wr && req.wdata[CTL_GO] && (phase_q == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b0;
            ien_q   <= 1'b0;
        end else begin
            if (ctl_wr)
                ien_q <= req.wdata[CTL_IEN];
            case (phase_q)
                PH_IDLE: begin
                    if (go_req)
                        phase_q <= PH_LAUNCH;
                    if (sts_wr && req.wdata[STS_DONE])
                        done_q <= 1'b0;
                end
                PH_LAUNCH: begin
                    phase_q <= PH_RUN;
                    done_q  <= 1'b0;
                end
                PH_RUN: begin
                    if (wr_last_done) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else if (sts_wr && req.wdata[STS_DONE]) begin
                        done_q <= 1'b0;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign lock        = (phase_q != PH_IDLE);
    assign start_pulse = (phase_q == PH_LAUNCH);
    assign busy        = (phase_q == PH_RUN);
    assign done        = done_q;
    assign ien         = ien_q;
    assign irq         = done_q && ien_q;

endmodule

// File: rtl/imgdma_cfg.sv
module imgdma_cfg
    import imgdma_pkg::*;
#(
    parameter int unsigned      PADDR_W = 12,
    parameter int unsigned      DIM_W   = 16,
    parameter logic [REG_W-1:0] SRC_LO  = 32'h6000_0000,
    parameter logic [REG_W-1:0] SRC_HI  = 32'h61FF_FFFF,
    parameter logic [REG_W-1:0] DST_LO  = 32'h6300_0000,
    parameter logic [REG_W-1:0] DST_HI  = 32'h65FF_FFFF,
    localparam int unsigned     PIX_W   = 2 * DIM_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [PADDR_W-1:0] paddr,
    input  logic [REG_W-1:0]   pwdata,
    output logic [REG_W-1:0]   prdata,
    output logic               pready,
    output logic               pslverr,
    output logic [REG_W-1:0]   src_addr,
    output logic [REG_W-1:0]   dst_addr,
    output logic [DIM_W-1:0]   img_width,
    output logic [DIM_W-1:0]   img_height,
    output logic [PIX_W-1:0]   pixel_count,
    output logic               start_pulse,
    output logic               busy,
    input  logic               wr_last_done,
    output logic               irq
);

    apb_req_t req;
    logic     lock;
    logic     done;
    logic     ien;

    imgdma_apb_dec #(.PADDR_W(PADDR_W)) u_dec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .req     (req)
    );

    imgdma_cfg_regs #(
        .DIM_W  (DIM_W),
        .SRC_LO (SRC_LO),
        .SRC_HI (SRC_HI),
        .DST_LO (DST_LO),
        .DST_HI (DST_HI)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .lock        (lock),
        .src_addr    (src_addr),
        .dst_addr    (dst_addr),
        .img_width   (img_width),
        .img_height  (img_height),
        .pixel_count (pixel_count)
    );

    imgdma_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .wr_last_done (wr_last_done),
        .lock         (lock),
        .start_pulse  (start_pulse),
        .busy         (busy),
        .done         (done),
        .ien          (ien),
        .irq          (irq)
    );

    always_comb begin
        prdata = '0;
        if (psel) begin
            case (req.sel)
                RSEL_SRC: prdata = src_addr;
                RSEL_DST: prdata = dst_addr;
                RSEL_WID: prdata = REG_W'(img_width);
                RSEL_HGT: prdata = REG_W'(img_height);
                RSEL_CTL: prdata[CTL_IEN] = ien;
                RSEL_STS: begin
                    prdata[STS_BUSY] = busy;
                    prdata[STS_DONE] = done;
                end
                default: prdata = '0;
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: rtl/imgdma_cfg_chk.sv
module imgdma_cfg_chk
    import imgdma_pkg::*;
#(
    parameter int unsigned      PADDR_W = 12,
    parameter int unsigned      DIM_W   = 16,
    parameter logic [REG_W-1:0] SRC_LO  = 32'h6000_0000,
    parameter logic [REG_W-1:0] SRC_HI  = 32'h61FF_FFFF,
    parameter logic [REG_W-1:0] DST_LO  = 32'h6300_0000,
    parameter logic [REG_W-1:0] DST_HI  = 32'h65FF_FFFF
) (
    input logic               clk,
    input logic               rst,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [PADDR_W-1:0] paddr,
    input logic [REG_W-1:0]   pwdata,
    input logic               pready,
    input logic               pslverr,
    input logic [REG_W-1:0]   src_addr,
    input logic [REG_W-1:0]   dst_addr,
    input logic [DIM_W-1:0]   img_width,
    input logic               start_pulse,
    input logic               busy,
    input logic               wr_last_done,
    input logic               irq
);

    logic apb_wr;
    assign apb_wr = psel && penable && pwrite;

    // R2
    apb_nowait_chk: assert property (@(posedge clk) disable iff (rst)
        pready && !pslverr);

    // R4
    src_window_chk: assert property (@(posedge clk) disable iff (rst)
        (src_addr >= SRC_LO) && (src_addr <= SRC_HI));

    // R4
    dst_window_chk: assert property (@(posedge clk) disable iff (rst)
        (dst_addr >= DST_LO) && (dst_addr <= DST_HI));

    // R5
    go_single_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    // R5
    go_then_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> busy);

    // R6
    busy_go_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && apb_wr && paddr == PADDR_W'(OFS_CTL) && pwdata[CTL_GO]) |=> !start_pulse);

    // R7
    busy_width_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && apb_wr && paddr == PADDR_W'(OFS_WID)) |=> $stable(img_width));

    // R9
    finish_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_last_done) |=> !busy);

    // R11
    irq_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> !busy);

endmodule

bind imgdma_cfg imgdma_cfg_chk #(
    .PADDR_W (PADDR_W),
    .DIM_W   (DIM_W),
    .SRC_LO  (SRC_LO),
    .SRC_HI  (SRC_HI),
    .DST_LO  (DST_LO),
    .DST_HI  (DST_HI)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .psel         (psel),
    .penable      (penable),
    .pwrite       (pwrite),
    .paddr        (paddr),
    .pwdata       (pwdata),
    .pready       (pready),
    .pslverr      (pslverr),
    .src_addr     (src_addr),
    .dst_addr     (dst_addr),
    .img_width    (img_width),
    .start_pulse  (start_pulse),
    .busy         (busy),
    .wr_last_done (wr_last_done),
    .irq          (irq)
);

// File: tb/imgdma_cfg_bench.sv
module imgdma_cfg_bench;

    localparam int unsigned PADDR_W = 12;
    localparam int unsigned DIM_W   = 16;
    localparam logic [11:0] A_SRC = 12'h000, A_DST = 12'h004, A_WID = 12'h008,
                            A_HGT = 12'h00C, A_CTL = 12'h010, A_STS = 12'h014;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [31:0] src_addr, dst_addr;
    logic [15:0] img_width, img_height;
    logic [31:0] pixel_count;
    logic        start_pulse, busy, irq;
    logic        wr_last_done = 1'b0;

    imgdma_cfg u_imgdma_cfg (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .src_addr(src_addr), .dst_addr(dst_addr),
        .img_width(img_width), .img_height(img_height), .pixel_count(pixel_count),
        .start_pulse(start_pulse), .busy(busy), .wr_last_done(wr_last_done), .irq(irq)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int bad    = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [31:0] m_src, m_dst;
    int unsigned m_w, m_h;
    bit          m_ien, m_done, m_busy, m_go;

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            A_SRC:   return m_src;
            A_DST:   return m_dst;
            A_WID:   return 32'(m_w);
            A_HGT:   return 32'(m_h);
            A_CTL:   return {30'd0, m_ien, 1'b0};
            A_STS:   return {30'd0, m_done, m_busy};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_src = 32'h6000_0000; m_dst = 32'h6300_0000;
            m_w = 0; m_h = 0; m_ien = 0; m_done = 0; m_busy = 0; m_go = 0;
        end else begin
            bit wr, frozen, fire;
            wr     = psel && penable && pwrite;
            frozen = m_busy || m_go;
            fire   = wr && paddr == A_CTL && pwdata[0] && !frozen;
            if (wr && !frozen) begin
                if (paddr == A_SRC && pwdata >= 32'h6000_0000 && pwdata <= 32'h61FF_FFFF) m_src = pwdata;
                if (paddr == A_DST && pwdata >= 32'h6300_0000 && pwdata <= 32'h65FF_FFFF) m_dst = pwdata;
                if (paddr == A_WID) m_w = pwdata[15:0];
                if (paddr == A_HGT) m_h = pwdata[15:0];
            end
            if (wr && paddr == A_CTL) m_ien = pwdata[1];
            if (m_go) begin
                m_busy = 1; m_done = 0;
            end else if (m_busy && wr_last_done) begin
                m_busy = 0; m_done = 1;
            end else if (wr && paddr == A_STS && pwdata[1]) begin
                m_done = 0;
            end
            m_go = fire;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 pready", pready, 1'b1);
            chk("R2 pslverr", pslverr, 1'b0);
            chk("R5 start_pulse", start_pulse, m_go);
            chk("R5 busy", busy, m_busy);
            chk("R11 irq", irq, m_done && m_ien);
            chk("R4 src", src_addr, m_src);
            chk("R4 dst", dst_addr, m_dst);
            chk("R7 width", img_width, m_w[15:0]);
            chk("R7 height", img_height, m_h[15:0]);
            chk("R8 pixels", pixel_count, 32'(m_w * m_h));
        end
    end

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d, input bit with_last = 0);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1; wr_last_done = with_last;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0; wr_last_done = 0;
    endtask

    task automatic apb_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1;
        chk(tag, prdata, exp);
        chk({tag, " model"}, prdata, m_read(a));
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic last_beat();
        @(negedge clk); wr_last_done = 1;
        @(negedge clk); wr_last_done = 0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 start_pulse", start_pulse, 0);
        chk("R1 irq", irq, 0);
        apb_rd(A_SRC, 32'h6000_0000, "R1 src");
        apb_rd(A_DST, 32'h6300_0000, "R1 dst");
        apb_rd(A_WID, 0, "R1 width");
        apb_rd(A_HGT, 0, "R1 height");
        apb_rd(A_CTL, 0, "R1 ctl");
        apb_rd(A_STS, 0, "R1 status");

        // R4 windows
        apb_wr(A_SRC, 32'h6000_1000);
        apb_rd(A_SRC, 32'h6000_1000, "R4 src in");
        apb_wr(A_SRC, 32'h6200_0000);
        apb_rd(A_SRC, 32'h6000_1000, "R4 src above");
        apb_wr(A_SRC, 32'h5FFF_FFFC);
        apb_rd(A_SRC, 32'h6000_1000, "R4 src below");
        apb_wr(A_DST, 32'h65FF_FF00);
        apb_rd(A_DST, 32'h65FF_FF00, "R4 dst in");
        apb_wr(A_DST, 32'h6600_0000);
        apb_rd(A_DST, 32'h65FF_FF00, "R4 dst above");

        // R3 map, R8 product
        apb_wr(A_WID, 32'hFFFF_0280);
        apb_wr(A_HGT, 32'd480);
        apb_rd(A_WID, 32'h0000_0280, "R3 width upper");
        apb_rd(A_HGT, 32'd480, "R3 height");
        chk("R8 product", pixel_count, 32'd307200);
        apb_wr(A_WID, 32'h0000_FFFF);
        apb_wr(A_HGT, 32'h0000_FFFF);
        chk("R8 max", pixel_count, 32'hFFFE_0001);
        apb_wr(A_WID, 32'd640);
        apb_wr(A_HGT, 32'd480);
        apb_wr(12'h018, 32'hFFFF_FFFF);
        apb_rd(12'h018, 0, "R3 undefined");
        apb_wr(12'h002, 32'h6100_0000);
        apb_rd(12'h002, 0, "R3 misaligned");
        apb_rd(A_SRC, 32'h6000_1000, "R3 misaligned no effect");
        apb_wr(A_CTL, 32'h2);
        apb_rd(A_CTL, 32'h2, "R3 ctl ien");

        // R5 launch
        apb_wr(A_CTL, 32'h3);
        chk("R5 pulse after access", start_pulse, 1);
        @(negedge clk);
        chk("R5 pulse one cycle", start_pulse, 0);
        chk("R5 busy next", busy, 1);
        apb_rd(A_STS, 32'h1, "R3 status busy");

        // R6, R7 while busy
        apb_wr(A_CTL, 32'h1);
        chk("R6 no pulse", start_pulse, 0);
        apb_rd(A_CTL, 32'h0, "R6 ien stored");
        apb_wr(A_CTL, 32'h2);
        apb_wr(A_WID, 32'd8);
        apb_wr(A_SRC, 32'h6100_0000);
        apb_rd(A_WID, 32'd640, "R7 width frozen");
        apb_rd(A_SRC, 32'h6000_1000, "R7 src frozen");

        // R9, R11 completion
        last_beat();
        chk("R9 busy off", busy, 0);
        chk("R11 irq on", irq, 1);
        apb_rd(A_STS, 32'h2, "R9 done");

        // R10 clear
        apb_wr(A_STS, 32'h1);
        apb_rd(A_STS, 32'h2, "R10 bit1 zero keeps");
        apb_wr(A_STS, 32'h2);
        apb_rd(A_STS, 32'h0, "R10 cleared");
        chk("R11 irq off", irq, 0);
        last_beat();
        apb_rd(A_STS, 32'h0, "R9 idle ignored");

        // R11 enable gating, R10 launch clears done
        apb_wr(A_CTL, 32'h1);
        @(negedge clk);
        last_beat();
        chk("R11 masked", irq, 0);
        apb_wr(A_CTL, 32'h2);
        chk("R11 unmasked", irq, 1);
        apb_wr(A_CTL, 32'h3);
        @(negedge clk);
        apb_rd(A_STS, 32'h1, "R10 launch clears done");

        // R10 same-cycle clear and completion
        apb_wr(A_STS, 32'h2, 1);
        apb_rd(A_STS, 32'h2, "R10 completion wins");
        chk("R11 irq after race", irq, 1);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule